// File: doc/BRIEF.md
# Serial handshake and suspend-wakeup controller

This block sits between a USB-to-serial bridge's control logic and its RS-232 line drivers. It produces the active-low request-to-send and data-terminal-ready outputs, an output enable for the transmit and handshake drivers, and a transceiver shutdown signal with its complement. Request-to-send either follows a host-written control bit, in either polarity, or tracks whether the downstream data buffer holds data, again in either polarity.

While the bus is suspended, the block drives the serial outputs inactive or releases them. A strap pin, sampled once after reset, chooses which. When enabled by configuration, the block also powers down the transceiver. It watches the five incoming modem lines through synchronizers. When an enabled line changes state during suspend, it raises one remote-wakeup pulse. Configuration decides whether that pulse is a resume request or a disconnect request. An inhibit bit blocks wakeup entirely.

Top module: `serial_hs_wake`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge: `rts_n`=1, `dtr_n`=1, `out_en`=0, `shtd_n`=1, `shtd`=0, and both wakeup outputs are 0.
- R2: When not suspended, with `cfg_rts_mode`=2'b00, `rts_n` equals the inverse of `host_rts`. With 2'b01, `rts_n` equals `host_rts`. `rts_n` updates one clock after its inputs.
- R3: When not suspended, with `cfg_rts_mode`=2'b10, `rts_n` is 0 while `dn_buf_empty`=0 and 1 otherwise. With 2'b11, `rts_n` is 1 while `dn_buf_empty`=0 and 0 otherwise.
- R4: When not suspended, `dtr_n` equals the inverse of `host_dtr`, one clock later.
- R5: `cfg_out_tristate`=1 forces `out_en`=0 one clock later, whatever the other inputs are.
- R6: During suspend, `rts_n` and `dtr_n` are 1. `out_en` is 1 if the captured strap is 1, and 0 if the captured strap is 0, unless R5 applies.
- R7: `strap_susp_drive` is captured on the first clock edge after reset is released. Later changes on that pin have no effect until the next reset.
- R8: `shtd_n`=0 and `shtd`=1 exactly when `suspend`=1 and `cfg_shdn_on_susp`=1, one clock later. Otherwise `shtd_n`=1 and `shtd`=0.
- R9: `modem_in` and `cfg_wake_en` share the bit order [0]=RXD, [1]=CTS, [2]=DSR, [3]=DCD, [4]=RI. A change on line k while suspended raises a wakeup pulse only if `cfg_wake_en[k]`=1. The pulse appears on the output after the third clock edge following the change.
- R10: A wakeup pulse comes out on `wake_resume` when `cfg_wake_resume`=1, and on `wake_disconnect` when it is 0. The two are never high together.
- R11: `cfg_wake_inhibit`=1 suppresses every wakeup pulse.
- R12: A wakeup pulse lasts exactly one cycle, and at most one is raised per suspend period. Arming returns when `suspend` falls. Line changes detected while not suspended raise no pulse, including a change whose detection falls in the cycle when `suspend` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rts_mode | input | 2 | Request-to-send source and polarity |
| cfg_wake_en | input | 5 | Per-line wakeup enables |
| cfg_wake_inhibit | input | 1 | Blocks all remote wakeup |
| cfg_wake_resume | input | 1 | 1: wakeup as resume, 0: as disconnect |
| cfg_shdn_on_susp | input | 1 | Shut the transceiver down during suspend |
| cfg_out_tristate | input | 1 | Force serial outputs to high impedance |
| host_rts | input | 1 | Host control bit for request-to-send |
| host_dtr | input | 1 | Host control bit for terminal-ready |
| dn_buf_empty | input | 1 | Downstream buffer empty flag |
| suspend | input | 1 | Bus suspend indication (synchronous) |
| strap_susp_drive | input | 1 | Strap: 1 drive inactive, 0 release during suspend |
| modem_in | input | 5 | Asynchronous modem inputs |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| out_en | output | 1 | Output enable for TXD, RTS, DTR drivers |
| shtd_n | output | 1 | Transceiver shutdown, active low |
| shtd | output | 1 | Inverse of `shtd_n` |
| wake_resume | output | 1 | One-cycle resume request |
| wake_disconnect | output | 1 | One-cycle disconnect request |

## Verification
The delicate overlap is between wakeup detection and the end of suspend. A modem-line change can reach the change detector in the same cycle that `suspend` falls, and that collision must produce no pulse. It must also leave no stale arming behind for the next suspend. The bench flips a line, waits exactly two clock edges so the change is being evaluated, and drops `suspend` at that point. It then expects zero pulses over the following cycles, and zero again after suspend is re-entered with the line steady. A second overlap, two enabled lines changing together, is judged by counting exactly one pulse.

// File: rtl/shw_pkg.sv
package shw_pkg;

   typedef enum logic [1:0] {
      RTS_HOST_LOW  = 2'b00,
      RTS_HOST_HIGH = 2'b01,
      RTS_BUF_ACT   = 2'b10,
      RTS_BUF_INACT = 2'b11
   } rts_mode_e;

   localparam int unsigned LINE_RXD = 0;
   localparam int unsigned LINE_CTS = 1;
   localparam int unsigned LINE_DSR = 2;
   localparam int unsigned LINE_DCD = 3;
   localparam int unsigned LINE_RI  = 4;
   localparam int unsigned N_MODEM  = 5;

endpackage

// File: rtl/shw_sync.sv
module shw_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("shw_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("shw_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/shw_line_drv.sv
module shw_line_drv
   import shw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rts_mode_e rts_mode,
   input  logic      cfg_shdn_on_susp,
   input  logic      cfg_out_tristate,
   input  logic      host_rts,
   input  logic      host_dtr,
   input  logic      dn_buf_empty,
   input  logic      suspend,
   input  logic      strap_susp_drive,
   output logic      rts_n,
   output logic      dtr_n,
   output logic      out_en,
   output logic      shtd_n,
   output logic      shtd
);

   logic strap_q;
   logic strap_done;
   logic rts_n_awake;
   logic rts_n_d, dtr_n_d, out_en_d, shdn_d;

   // Strap is taken once, on the first edge out of reset.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strap_q    <= 1'b1;
         strap_done <= 1'b0;
      end else if (!strap_done) begin
         strap_q    <= strap_susp_drive;
         strap_done <= 1'b1;
      end
   end

   always_comb begin
      unique case (rts_mode)
         RTS_HOST_LOW:  rts_n_awake = ~host_rts;
         RTS_HOST_HIGH: rts_n_awake =  host_rts;
         RTS_BUF_ACT:   rts_n_awake =  dn_buf_empty;
         RTS_BUF_INACT: rts_n_awake = ~dn_buf_empty;
         default:       rts_n_awake = 1'b1;
      endcase
   end

   always_comb begin
      rts_n_d  = suspend ? 1'b1 : rts_n_awake;
      dtr_n_d  = suspend ? 1'b1 : ~host_dtr;
      out_en_d = !cfg_out_tristate && !(suspend && !strap_q);
      shdn_d   = suspend && cfg_shdn_on_susp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rts_n  <= 1'b1;
         dtr_n  <= 1'b1;
         out_en <= 1'b0;
         shtd_n <= 1'b1;
         shtd   <= 1'b0;
      end else begin
         rts_n  <= rts_n_d;
         dtr_n  <= dtr_n_d;
         out_en <= out_en_d;
         shtd_n <= ~shdn_d;
         shtd   <= shdn_d;
      end
   end

   assert_tristate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out_tristate |=> !out_en);

   assert_awake_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !suspend |=> (shtd_n && !shtd));

   assert_susp_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      suspend |=> (rts_n && dtr_n));

   assert_strap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strap_done |=> $stable(strap_q));

endmodule

// File: rtl/shw_wake.sv
module shw_wake #(
   parameter int unsigned LINES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_sync,
   input  logic [LINES-1:0] cfg_wake_en,
   input  logic             cfg_wake_inhibit,
   input  logic             cfg_wake_resume,
   input  logic             suspend,
   output logic             wake_resume,
   output logic             wake_disconnect
);

   if (LINES < 1) begin : g_bad_lines
      $error("shw_wake: LINES must be at least 1");
   end

   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] hit;
   logic             armed_n;
   logic             fire;

   for (genvar k = 0; k < LINES; k++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q[k] <= 1'b0;
         else        prev_q[k] <= line_sync[k];
      end
      assign hit[k] = (line_sync[k] ^ prev_q[k]) & cfg_wake_en[k];
   end

   assign fire = suspend && !cfg_wake_inhibit && !armed_n && (|hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_n         <= 1'b0;
         wake_resume     <= 1'b0;
         wake_disconnect <= 1'b0;
      end else begin
         if (!suspend)  armed_n <= 1'b0;
         else if (fire) armed_n <= 1'b1;
         wake_resume     <= fire &&  cfg_wake_resume;
         wake_disconnect <= fire && !cfg_wake_resume;
      end
   end

   assert_kind_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake_resume && wake_disconnect));

   assert_single_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_resume || wake_disconnect) |=> !(wake_resume || wake_disconnect));

   assert_awake_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !suspend |=> !(wake_resume || wake_disconnect));

   assert_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wake_inhibit |=> !(wake_resume || wake_disconnect));

endmodule

// File: rtl/serial_hs_wake.sv
module serial_hs_wake
   import shw_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_rts_mode,
   input  logic [N_MODEM-1:0] cfg_wake_en,
   input  logic               cfg_wake_inhibit,
   input  logic               cfg_wake_resume,
   input  logic               cfg_shdn_on_susp,
   input  logic               cfg_out_tristate,
   input  logic               host_rts,
   input  logic               host_dtr,
   input  logic               dn_buf_empty,
   input  logic               suspend,
   input  logic               strap_susp_drive,
   input  logic [N_MODEM-1:0] modem_in,
   output logic               rts_n,
   output logic               dtr_n,
   output logic               out_en,
   output logic               shtd_n,
   output logic               shtd,
   output logic               wake_resume,
   output logic               wake_disconnect
);

   logic [N_MODEM-1:0] modem_sync;

   shw_sync #(.WIDTH(N_MODEM), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (modem_in),
      .q_sync  (modem_sync)
   );

   shw_line_drv u_drv (
      .clk              (clk),
      .rst_n            (rst_n),
      .rts_mode         (rts_mode_e'(cfg_rts_mode)),
      .cfg_shdn_on_susp (cfg_shdn_on_susp),
      .cfg_out_tristate (cfg_out_tristate),
      .host_rts         (host_rts),
      .host_dtr         (host_dtr),
      .dn_buf_empty     (dn_buf_empty),
      .suspend          (suspend),
      .strap_susp_drive (strap_susp_drive),
      .rts_n            (rts_n),
      .dtr_n            (dtr_n),
      .out_en           (out_en),
      .shtd_n           (shtd_n),
      .shtd             (shtd)
   );

   shw_wake #(.LINES(N_MODEM)) u_wake (
      .clk              (clk),
      .rst_n            (rst_n),
      .line_sync        (modem_sync),
      .cfg_wake_en      (cfg_wake_en),
      .cfg_wake_inhibit (cfg_wake_inhibit),
      .cfg_wake_resume  (cfg_wake_resume),
      .suspend          (suspend),
      .wake_resume      (wake_resume),
      .wake_disconnect  (wake_disconnect)
   );

   assert_shdn_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shtd != shtd_n);

endmodule

// File: tb/serial_hs_wake_tb.sv
`timescale 1ns/1ps
module serial_hs_wake_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_rts_mode = 2'b00;
   logic [4:0] cfg_wake_en = 5'b0;
   logic       cfg_wake_inhibit = 1'b0;
   logic       cfg_wake_resume = 1'b1;
   logic       cfg_shdn_on_susp = 1'b0;
   logic       cfg_out_tristate = 1'b0;
   logic       host_rts = 1'b0;
   logic       host_dtr = 1'b0;
   logic       dn_buf_empty = 1'b1;
   logic       suspend = 1'b0;
   logic       strap_susp_drive = 1'b1;
   logic [4:0] modem_in = 5'b0;
   logic       rts_n, dtr_n, out_en, shtd_n, shtd, wake_resume, wake_disconnect;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serial_hs_wake u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_rts_mode(cfg_rts_mode),
      .cfg_wake_en(cfg_wake_en), .cfg_wake_inhibit(cfg_wake_inhibit),
      .cfg_wake_resume(cfg_wake_resume), .cfg_shdn_on_susp(cfg_shdn_on_susp),
      .cfg_out_tristate(cfg_out_tristate), .host_rts(host_rts),
      .host_dtr(host_dtr), .dn_buf_empty(dn_buf_empty), .suspend(suspend),
      .strap_susp_drive(strap_susp_drive), .modem_in(modem_in),
      .rts_n(rts_n), .dtr_n(dtr_n), .out_en(out_en), .shtd_n(shtd_n),
      .shtd(shtd), .wake_resume(wake_resume), .wake_disconnect(wake_disconnect)
   );

   // {mode[1:0], host_rts, host_dtr, empty, tristate, suspend, shdn, exp rts_n, dtr_n, out_en, shtd_n}
   localparam int NV = 13;
   localparam logic [11:0] VEC [NV] = '{
      12'b00_111000_0011,  // R2 R4 host low-active, asserted
      12'b00_001000_1111,  // R2 R4 host low-active, released
      12'b01_101000_1111,  // R2 host high-active
      12'b01_011000_0011,  // R2 R4
      12'b10_000000_0111,  // R3 buffer holds data -> active
      12'b10_111000_1011,  // R3 buffer empty -> inactive
      12'b11_000000_1111,  // R3 inverted, data -> inactive
      12'b11_001000_0111,  // R3 inverted, empty -> active
      12'b00_111100_0001,  // R5 tristate
      12'b00_111010_1111,  // R6 suspend, strap high
      12'b00_111011_1110,  // R8 suspend with shutdown
      12'b00_111001_0011,  // R8 shutdown bit without suspend
      12'b10_010111_1100   // R5 R6 R8 combined
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic watch(input int n, output int nr, output int nd, output int first);
      nr = 0; nd = 0; first = -1;
      for (int i = 1; i <= n; i++) begin
         tick();
         if ((wake_resume || wake_disconnect) && first < 0) first = i;
         nr += int'(wake_resume);
         nd += int'(wake_disconnect);
      end
   endtask

   task automatic do_reset(input logic strap);
      strap_susp_drive = strap;
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic rearm();
      suspend = 1'b0;
      repeat (4) tick();
      suspend = 1'b1;
      repeat (2) tick();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int nr, nd, first;
      // R1 reset values
      repeat (3) tick();
      check("R1 rts_n", rts_n, 1);
      check("R1 dtr_n", dtr_n, 1);
      check("R1 out_en", out_en, 0);
      check("R1 shtd_n", shtd_n, 1);
      check("R1 shtd", shtd, 0);
      check("R1 wake", int'(wake_resume) + int'(wake_disconnect), 0);
      rst_n = 1'b1;
      tick();

      for (int v = 0; v < NV; v++) begin
         {cfg_rts_mode, host_rts, host_dtr, dn_buf_empty,
          cfg_out_tristate, suspend, cfg_shdn_on_susp} = VEC[v][11:4];
         tick();
         check($sformatf("R2 R3 R4 R5 R6 R8 vec%0d", v),
               int'({rts_n, dtr_n, out_en, shtd_n}), int'(VEC[v][3:0]));
         check($sformatf("R8 shtd vec%0d", v), shtd, int'(!VEC[v][0]));
      end

      cfg_out_tristate = 1'b0; suspend = 1'b0; cfg_shdn_on_susp = 1'b0;
      cfg_wake_en = 5'b11111; cfg_wake_resume = 1'b1; cfg_wake_inhibit = 1'b0;
      repeat (4) tick();
      suspend = 1'b1;
      repeat (2) tick();

      // R9 R10: RXD change, resume, third edge
      modem_in[0] = ~modem_in[0];
      watch(8, nr, nd, first);
      check("R9 pulse count", nr, 1);
      check("R10 no disconnect", nd, 0);
      check("R9 latency", first, 3);

      // R12 once per suspend
      modem_in[1] = ~modem_in[1];
      watch(8, nr, nd, first);
      check("R12 single per suspend", nr + nd, 0);

      // R12 changes while awake ignored
      suspend = 1'b0;
      tick();
      modem_in[2] = ~modem_in[2];
      watch(6, nr, nd, first);
      check("R12 awake change", nr + nd, 0);

      // R10 disconnect
      cfg_wake_resume = 1'b0;
      suspend = 1'b1;
      repeat (2) tick();
      modem_in[2] = ~modem_in[2];
      watch(8, nr, nd, first);
      check("R10 disconnect", nd, 1);
      check("R10 no resume", nr, 0);

      // R9 disabled line ignored, enabled one fires
      rearm();
      cfg_wake_en = 5'b10000;
      modem_in[3] = ~modem_in[3];
      watch(8, nr, nd, first);
      check("R9 DCD disabled", nr + nd, 0);
      modem_in[4] = ~modem_in[4];
      watch(8, nr, nd, first);
      check("R9 RI enabled", nd, 1);

      // R11 inhibit
      rearm();
      cfg_wake_en = 5'b11111; cfg_wake_inhibit = 1'b1; cfg_wake_resume = 1'b1;
      modem_in[0] = ~modem_in[0];
      watch(8, nr, nd, first);
      check("R11 inhibited", nr + nd, 0);
      cfg_wake_inhibit = 1'b0;

      // R9 two lines at once give one pulse
      rearm();
      modem_in[1] = ~modem_in[1];
      modem_in[2] = ~modem_in[2];
      watch(8, nr, nd, first);
      check("R9 two lines one pulse", nr, 1);

      // R12 collision: detection in the cycle suspend falls
      rearm();
      modem_in[3] = ~modem_in[3];
      repeat (2) tick();
      suspend = 1'b0;
      watch(6, nr, nd, first);
      check("R12 collision no pulse", nr + nd, 0);
      suspend = 1'b1;
      watch(6, nr, nd, first);
      check("R12 no stale pulse", nr + nd, 0);

      // R7 R6: strap low captured, later raise ignored
      suspend = 1'b0;
      do_reset(1'b0);
      strap_susp_drive = 1'b1;
      repeat (2) tick();
      check("R6 awake out_en", out_en, 1);
      suspend = 1'b1;
      tick();
      check("R7 R6 strap low released", out_en, 0);
      check("R6 rts inactive", rts_n, 1);
      suspend = 1'b0;
      do_reset(1'b1);
      suspend = 1'b1;
      tick();
      check("R7 strap high drives", out_en, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule